// File: doc/BRIEF.md
# Second-Operand Shifter

This combinational block produces the second operand of a 32-bit ALU together with the shifter carry. The first ALU operand does not pass through it. It selects between two sources.

The first source is an 8-bit constant that is zero-extended and rotated right by twice a 4-bit field. The second source is a register value. That value is shifted left or right, arithmetically shifted, or rotated. The amount comes either from a 5-bit field in the instruction or from the low byte of a second register. That byte may hold amounts well beyond the word width.

The carry output goes to the flag logic. The operand output goes straight to the ALU input. The block has no clock and no state, so both results are valid in the same cycle as the inputs.

Top module: `so_operand2`

## Requirements
- R1: With `use_imm` high, `operand_out` is `imm_val` zero-extended to 32 bits and rotated right by 2×`imm_rot` bit positions.
- R2: With `use_imm` high, `carry_out` equals bit 31 of `operand_out` when `imm_rot` is nonzero, and equals `carry_in` when `imm_rot` is zero.
- R3: `sh_kind` encodes 00 = logical left, 01 = logical right, 10 = arithmetic right, 11 = rotate right. For an instruction amount `sh_amt_imm` of 1 to 31, the value `rm_val` is shifted by that amount. `carry_out` is the last bit shifted out: `rm_val[32-n]` for a left shift and `rm_val[n-1]` for any right shift or rotate.
- R4: For an instruction amount of 0, logical left passes `rm_val` with `carry_in` unchanged. Logical right gives 0 with carry `rm_val[31]`. Arithmetic right gives 32 copies of `rm_val[31]` with carry `rm_val[31]`.
- R5: For an instruction amount of 0 with rotate right, the result is `{carry_in, rm_val[31:1]}` and the carry is `rm_val[0]`.
- R6: With `amt_from_reg` high, the amount is `shamt_reg`. A value of 0 passes `rm_val` with `carry_in` unchanged for every shift kind.
- R7: With a register amount, a logical shift by exactly 32 gives 0, with carry `rm_val[0]` for a left shift and `rm_val[31]` for a right shift. A logical shift by more than 32 gives 0 with carry 0.
- R8: With a register amount of 32 or more, arithmetic right gives 32 copies of `rm_val[31]` with carry `rm_val[31]`.
- R9: With a nonzero register amount, rotate right uses the amount modulo 32. A nonzero multiple of 32 returns `rm_val` unchanged. In every such case the carry equals bit 31 of the result.
- R10: Register amounts from 1 to 31 shift exactly as the same instruction amounts do in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_imm | input | 1 | 1 selects the rotated constant, 0 selects the shifted register |
| imm_val | input | 8 | Constant before rotation |
| imm_rot | input | 4 | Half of the constant's rotate-right amount |
| rm_val | input | 32 | Register value to be shifted |
| amt_from_reg | input | 1 | 1 takes the shift amount from `shamt_reg`, 0 from `sh_amt_imm` |
| sh_amt_imm | input | 5 | Shift amount carried in the instruction |
| shamt_reg | input | 8 | Low byte of the amount register |
| sh_kind | input | 2 | Shift kind, encoded as in R3 |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench drives constants at every rotate step, including zero and nonzero rotations. These patterns separate a wrong rotate step size from a wrong carry source. It sweeps instruction amounts through 0, 1, 31 and random middle values for all four kinds, which separates the special zero encodings from ordinary shifts. Register amounts are aimed at 0, 1, 31, 32, 33, 64 and 255 plus random bytes, so the pass-through, the exact-width carry, the saturated result and the modulo rotate each show up as their own mismatch. Operands with patterned bits and sign bits set and clear expose any misplaced fill or carry bit.

// File: rtl/so_pkg.sv
package so_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    OP_PASS  = 2'b00,
    OP_SHIFT = 2'b01,
    OP_RRX   = 2'b10
  } shift_op_e;
endpackage

// File: rtl/so_imm_rot.sv
module so_imm_rot #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic [IMM_W-1:0] imm_val,
  input  logic [ROT_W-1:0] imm_rot,
  input  logic             carry_in,
  output logic [XLEN-1:0]  rot_out,
  output logic             rot_carry
);
  localparam int AMT_W = ROT_W + 1;

  logic [AMT_W-1:0]  rot_amt;
  logic [XLEN-1:0]   ext_val;
  logic [2*XLEN-1:0] dbl;

  always_comb begin
    rot_amt   = {imm_rot, 1'b0};
    ext_val   = XLEN'(imm_val);
    dbl       = {ext_val, ext_val} >> rot_amt;
    rot_out   = dbl[XLEN-1:0];
    rot_carry = (imm_rot != '0) ? rot_out[XLEN-1] : carry_in;
  end
endmodule

// File: rtl/so_amt_dec.sv
module so_amt_dec
  import so_pkg::*;
#(
  parameter int SH_W   = 5,
  parameter int RAMT_W = 8
) (
  input  logic              amt_from_reg,
  input  logic [SH_W-1:0]   sh_amt_imm,
  input  logic [RAMT_W-1:0] shamt_reg,
  input  shift_kind_e       kind,
  output shift_op_e         op,
  output logic [SH_W:0]     eff_amt
);
  localparam int XLEN = 1 << SH_W;
  localparam logic [RAMT_W-1:0] FULL = RAMT_W'(XLEN);
  localparam logic [SH_W:0]     SAT  = (SH_W+1)'(XLEN + 1);
  localparam logic [SH_W:0]     WID  = (SH_W+1)'(XLEN);

  always_comb begin
    op      = OP_SHIFT;
    eff_amt = {1'b0, sh_amt_imm};
    if (amt_from_reg) begin
      if (shamt_reg == '0) begin
        op = OP_PASS;
      end else begin
        unique case (kind)
          SK_ROR: eff_amt = {1'b0, shamt_reg[SH_W-1:0]};
          SK_ASR: eff_amt = (shamt_reg >= FULL) ? WID : (SH_W+1)'(shamt_reg);
          default: eff_amt = (shamt_reg > FULL) ? SAT : (SH_W+1)'(shamt_reg);
        endcase
      end
    end else if (sh_amt_imm == '0) begin
      unique case (kind)
        SK_LSL: op = OP_PASS;
        SK_ROR: op = OP_RRX;
        default: eff_amt = WID;
      endcase
    end
  end
endmodule

// File: rtl/so_shift_core.sv
module so_shift_core
  import so_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  shift_op_e                 op,
  input  shift_kind_e               kind,
  input  logic [$clog2(XLEN):0]     amt,
  input  logic [XLEN-1:0]           val,
  input  logic                      carry_in,
  output logic [XLEN-1:0]           res,
  output logic                      cout
);
  localparam int SH_W = $clog2(XLEN);

  logic [XLEN:0]        lsl_w;
  logic [XLEN:0]        lsr_w;
  logic signed [XLEN:0] asr_src;
  logic signed [XLEN:0] asr_w;
  logic [2*XLEN-1:0]    ror_w;

  always_comb begin
    lsl_w   = {1'b0, val} << amt;
    lsr_w   = {val, 1'b0} >> amt;
    asr_src = {val, 1'b0};
    asr_w   = asr_src >>> amt;
    ror_w   = {val, val} >> amt[SH_W-1:0];
    res     = val;
    cout    = carry_in;
    unique case (op)
      OP_RRX: begin
        res  = {carry_in, val[XLEN-1:1]};
        cout = val[0];
      end
      OP_SHIFT: begin
        unique case (kind)
          SK_LSL: begin res = lsl_w[XLEN-1:0]; cout = lsl_w[XLEN]; end
          SK_LSR: begin res = lsr_w[XLEN:1];   cout = lsr_w[0];    end
          SK_ASR: begin res = asr_w[XLEN:1];   cout = asr_w[0];    end
          default: begin
            res  = ror_w[XLEN-1:0];
            cout = ror_w[XLEN-1];
          end
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/so_operand2.sv
module so_operand2
  import so_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int SH_W   = 5,
  parameter int RAMT_W = 8
) (
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic [ROT_W-1:0]  imm_rot,
  input  logic [XLEN-1:0]   rm_val,
  input  logic              amt_from_reg,
  input  logic [SH_W-1:0]   sh_amt_imm,
  input  logic [RAMT_W-1:0] shamt_reg,
  input  logic [1:0]        sh_kind,
  input  logic              carry_in,
  output logic [XLEN-1:0]   operand_out,
  output logic              carry_out
);
  localparam logic [RAMT_W-1:0] FULL = RAMT_W'(XLEN);

  shift_kind_e     kind;
  shift_op_e       op;
  logic [SH_W:0]   eff_amt;
  logic [XLEN-1:0] rot_out;
  logic            rot_carry;
  logic [XLEN-1:0] sh_out;
  logic            sh_carry;

  assign kind = shift_kind_e'(sh_kind);

  so_imm_rot #(.XLEN(XLEN), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .imm_val  (imm_val),
    .imm_rot  (imm_rot),
    .carry_in (carry_in),
    .rot_out  (rot_out),
    .rot_carry(rot_carry)
  );

  so_amt_dec #(.SH_W(SH_W), .RAMT_W(RAMT_W)) u_dec (
    .amt_from_reg(amt_from_reg),
    .sh_amt_imm  (sh_amt_imm),
    .shamt_reg   (shamt_reg),
    .kind        (kind),
    .op          (op),
    .eff_amt     (eff_amt)
  );

  so_shift_core #(.XLEN(XLEN)) u_core (
    .op      (op),
    .kind    (kind),
    .amt     (eff_amt),
    .val     (rm_val),
    .carry_in(carry_in),
    .res     (sh_out),
    .cout    (sh_carry)
  );

  always_comb begin
    operand_out = use_imm ? rot_out   : sh_out;
    carry_out   = use_imm ? rot_carry : sh_carry;
  end

  always_comb begin
    if (use_imm) begin
      AST_IMM_ONES: assert ($countones(operand_out) == $countones(imm_val))
        else $error("constant rotate changed bit count"); // R1
    end
    if (use_imm && imm_rot != '0) begin
      AST_IMM_CARRY: assert (carry_out == operand_out[XLEN-1])
        else $error("rotated constant carry not msb"); // R2
    end
    if (!use_imm && amt_from_reg && shamt_reg == '0) begin
      AST_REG_ZERO_PASS: assert (operand_out == rm_val && carry_out == carry_in)
        else $error("zero register amount altered value"); // R6
    end
    if (!use_imm && amt_from_reg && shamt_reg > FULL && sh_kind[1] == 1'b0) begin
      AST_LOGIC_FAR: assert (operand_out == '0 && !carry_out)
        else $error("far logical shift not cleared"); // R7
    end
    if (!use_imm && amt_from_reg && shamt_reg >= FULL && kind == SK_ASR) begin
      AST_ASR_SIGN: assert (operand_out == {XLEN{rm_val[XLEN-1]}} && carry_out == rm_val[XLEN-1])
        else $error("far arithmetic shift not sign filled"); // R8
    end
    if (!use_imm && amt_from_reg && shamt_reg != '0 && kind == SK_ROR) begin
      AST_ROR_ONES: assert ($countones(operand_out) == $countones(rm_val)
                            && carry_out == operand_out[XLEN-1])
        else $error("register rotate lost bits"); // R9
    end
  end
endmodule

// File: tb/so_operand2_bench.sv
module so_operand2_bench;
  logic        clk;
  logic        use_imm;
  logic [7:0]  imm_val;
  logic [3:0]  imm_rot;
  logic [31:0] rm_val;
  logic        amt_from_reg;
  logic [4:0]  sh_amt_imm;
  logic [7:0]  shamt_reg;
  logic [1:0]  sh_kind;
  logic        carry_in;
  logic [31:0] operand_out;
  logic        carry_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  so_operand2 u_so_operand2 (
    .use_imm(use_imm), .imm_val(imm_val), .imm_rot(imm_rot), .rm_val(rm_val),
    .amt_from_reg(amt_from_reg), .sh_amt_imm(sh_amt_imm), .shamt_reg(shamt_reg),
    .sh_kind(sh_kind), .carry_in(carry_in),
    .operand_out(operand_out), .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural model: one bit position per step.
  function automatic void model(output logic [31:0] r, output logic c);
    int n;
    r = rm_val;
    c = carry_in;
    if (use_imm) begin
      r = {24'd0, imm_val};
      for (int i = 0; i < 2 * int'(imm_rot); i++) r = {r[0], r[31:1]};
      if (imm_rot != 0) c = r[31];
      return;
    end
    n = amt_from_reg ? int'(shamt_reg) : int'(sh_amt_imm);
    if (!amt_from_reg && n == 0) begin
      if (sh_kind == 2'b01 || sh_kind == 2'b10) n = 32;
      else if (sh_kind == 2'b11) begin
        r = {carry_in, rm_val[31:1]};
        c = rm_val[0];
        return;
      end
    end
    for (int i = 0; i < n; i++) begin
      case (sh_kind)
        2'b00: begin c = r[31]; r = r << 1; end
        2'b01: begin c = r[0];  r = r >> 1; end
        2'b10: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endfunction

  function automatic string tag_of();
    if (use_imm) return (imm_rot != 0) ? "R2" : "R1";
    if (!amt_from_reg) begin
      if (sh_amt_imm != 0) return "R3";
      return (sh_kind == 2'b11) ? "R5" : "R4";
    end
    if (shamt_reg == 0) return "R6";
    if (sh_kind == 2'b11) return "R9";
    if (shamt_reg < 32) return "R10";
    if (sh_kind == 2'b10) return "R8";
    return "R7";
  endfunction

  task automatic run(input logic ui, input logic [7:0] iv, input logic [3:0] ir,
                     input logic [31:0] rv, input logic fr, input logic [4:0] sa,
                     input logic [7:0] sr, input logic [1:0] k, input logic ci);
    logic [31:0] er;
    logic        ec;
    @(posedge clk);
    use_imm = ui; imm_val = iv; imm_rot = ir; rm_val = rv; amt_from_reg = fr;
    sh_amt_imm = sa; shamt_reg = sr; sh_kind = k; carry_in = ci;
    @(negedge clk);
    model(er, ec);
    total++;
    if (operand_out !== er || carry_out !== ec) begin
      bad++;
      $display("FAIL %s: got %h/%b expected %h/%b", tag_of(), operand_out, carry_out, er, ec);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] far_amts [7];
    far_amts = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd64, 8'd255};
    // R1 R2: constant rotations
    run(1, 8'hFF, 4'd0, 32'h0, 0, 0, 0, 0, 1);
    run(1, 8'hFF, 4'd1, 32'h0, 0, 0, 0, 0, 0);
    run(1, 8'hAB, 4'd4, 32'h0, 0, 0, 0, 0, 0);
    run(1, 8'h01, 4'd15, 32'h0, 0, 0, 0, 0, 1);
    // R3 R4 R5: instruction amounts
    for (int k = 0; k < 4; k++) begin
      run(0, 0, 0, 32'h8000_0001, 0, 5'd0, 0, 2'(k), 1);
      run(0, 0, 0, 32'h8000_0001, 0, 5'd0, 0, 2'(k), 0);
      run(0, 0, 0, 32'h7F00_00F1, 0, 5'd1, 0, 2'(k), 0);
      run(0, 0, 0, 32'hC350_A5A5, 0, 5'd31, 0, 2'(k), 1);
    end
    // R6 R7 R8 R9 R10: register amounts
    for (int k = 0; k < 4; k++)
      foreach (far_amts[j]) begin
        run(0, 0, 0, 32'h8000_0001, 1, 0, far_amts[j], 2'(k), 1);
        run(0, 0, 0, 32'h4ABC_DEF3, 1, 0, far_amts[j], 2'(k), 0);
      end
    for (int i = 0; i < 600; i++)
      run(1'($urandom), 8'($urandom), 4'($urandom), $urandom, 1'($urandom),
          5'($urandom), (i % 3 == 0) ? 8'($urandom % 40) : 8'($urandom),
          2'($urandom), 1'($urandom));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule